// File: doc/BRIEF.md
# Serial Flash Controller Register Bank

This block is the 32-bit memory-mapped register bank that sits in front of a serial flash transaction engine. Software uses it to program the direct-read and direct-write settings, to set up a user-mode transfer (opcode, address, up to sixteen bytes of write data, sizes), and to start that transfer. The bank hands the settings to the engine on plain output buses, emits a one-cycle start pulse, and collects up to four words of returned read data over a small write port that only the engine can use.

Three of the configuration words lock themselves: once their top bit is set, further writes to them are dropped. The user-mode configuration word also has a softer lock that freezes only three of its fields. The control/status word carries a sticky execute flag that software cannot clear, a ready flag that software clears by writing a one, an interrupt enable, and a software chip-select bit. Toggling that bit drives one of the active-low chip-select outputs directly. Protection-table words are present in the map, but they accept writes without effect.

Top module: `sflash_regbank`

## Requirements
- R1: After reset, word reads return 0x0300100B at byte 0x00, 0x03000002 at 0x04, 0x00000400 at 0x08, 0x00010000 at 0x0C, 0x0000000B at 0x10, 0x00000400 at 0x18, and 0x0000000B at 0x78. Every other word reads 0, all chip selects are high, and the interrupt is low.
- R2: A write to the direct-read word (0x00), the direct-write word (0x04) or the user-mode config word (0x08) is dropped in full when bit 31 of that word is already 1.
- R3: While bit 30 of the user-mode config word is 1, a write to it leaves bits 0, 1 and 10 (mask 0x403) at their old values and takes all other bits from the write data.
- R4: Bit 24 of the control/status word (0x0C) is set when the engine reports completion. Writing 1 to it clears it, and writing 0 leaves it as it is. A completion takes effect before a write in the same cycle.
- R5: Writing 1 to control/status bit 0 while it is 0 sets it and raises the start output for exactly the cycle after the write. Bit 0 stays 1 through writes of 0 until the engine reports completion, which clears it. Writing 1 while it is already 1 gives no new pulse.
- R6: A write that changes control/status bit 16 from 1 to 0 drives low the chip select numbered by write bits 9:8, or none if that number is not below the chip-select count. A write that changes bit 16 from 0 to 1 releases the chip select, unless bit 0 is set before the write or in the write data. At most one chip select is low at any time.
- R7: The four read-data words (0x30 to 0x3C) take values only from the engine's write port (word select 0 to 3). Bus writes to them are ignored.
- R8: Writes to the protection words (0x18 and 0x40 to 0x64) are ignored, so 0x18 keeps reading 0x400 and the others read 0. Writes to offsets that are not word-aligned are ignored, and reads from them, from unused offsets, or from outside the 128-byte map return 0.
- R9: The interrupt output is high exactly when control/status bit 24 and bit 25 are both 1.
- R10: The command (0x10), address (0x14), four write-data words (0x20 to 0x2C) and the global word (0x78) store what is written. A read returns its data on the read-data port in the cycle after the read strobe and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| xfer_start | output | 1 | One-cycle pulse that starts a user-mode transfer |
| xfer_done | input | 1 | Engine reports the transfer finished |
| rdbuf_we | input | 1 | Engine writes a read-data word |
| rdbuf_sel | input | 2 | Which read-data word the engine writes |
| rdbuf_data | input | 32 | Read data from the engine |
| rd_cfg_o | output | 32 | Direct-read configuration |
| wr_cfg_o | output | 32 | Direct-write configuration |
| um_cfg_o | output | 32 | User-mode configuration |
| um_cmd_o | output | 32 | User-mode command word |
| um_addr_o | output | 32 | User-mode address |
| um_wdata_o | output | 128 | The four write-data words, word 0 in the low bits |
| flash_cs_n | output | NUM_CS | Active-low chip selects |
| irq | output | 1 | Ready interrupt |

## Verification
Every register update, the chip-select change and the start pulse appear one clock after the edge that samples the write strobe. Read data appears one clock after the edge that samples the read strobe, and the interrupt follows the stored status with no extra delay. The bench drives inputs on the falling edge, and its reference model advances on the same rising edge as the design, so each comparison on the next falling edge already sees the result that is due. The directed reads therefore check their value on the falling edge that follows the read cycle.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  typedef logic [4:0] widx_t;

  localparam widx_t W_DRD  = 5'd0;
  localparam widx_t W_DWR  = 5'd1;
  localparam widx_t W_UCFG = 5'd2;
  localparam widx_t W_CTS  = 5'd3;
  localparam widx_t W_CMD  = 5'd4;
  localparam widx_t W_ADR  = 5'd5;
  localparam widx_t W_PCFG = 5'd6;
  localparam widx_t W_DW0  = 5'd8;
  localparam widx_t W_DR0  = 5'd12;
  localparam widx_t W_GCFG = 5'd30;

  localparam int B_LOCK = 31;
  localparam int B_CMM  = 30;
  localparam int B_IE   = 25;
  localparam int B_RDY  = 24;
  localparam int B_SWCS = 16;
  localparam int B_EXEC = 0;

  localparam logic [31:0] CMM_MASK  = 32'h0000_0403;
  localparam logic [31:0] CTS_RST   = 32'h0001_0000;
  localparam logic [31:0] CMD_RST   = 32'h0000_000B;
  localparam logic [31:0] PCFG_RST  = 32'h0000_0400;
  localparam logic [31:0] GCFG_RST  = 32'h0000_000B;

  function automatic logic [31:0] cfg_rst(input int idx);
    case (idx)
      0:       return 32'h0300_100B;
      1:       return 32'h0300_0002;
      default: return 32'h0000_0400;
    endcase
  endfunction

  // Next value of a self-locking configuration word after a bus write.
  function automatic logic [31:0] cfg_next(input logic [31:0] old,
                                           input logic [31:0] wv,
                                           input logic has_cmm);
    if (old[B_LOCK]) return old;
    if (has_cmm && old[B_CMM]) return (wv & ~CMM_MASK) | (old & CMM_MASK);
    return wv;
  endfunction

  // Control/status after an engine completion, applied before any write.
  function automatic logic [31:0] cts_complete(input logic [31:0] old,
                                               input logic done);
    logic [31:0] r;
    r = old;
    if (done) begin
      r[B_EXEC] = 1'b0;
      r[B_RDY]  = 1'b1;
    end
    return r;
  endfunction

  // Control/status after a bus write: ready is write-one-to-clear, execute is sticky.
  function automatic logic [31:0] cts_merge(input logic [31:0] base,
                                            input logic [31:0] wv);
    logic [31:0] r;
    r         = wv;
    r[B_RDY]  = wv[B_RDY] ? 1'b0 : base[B_RDY];
    r[B_EXEC] = base[B_EXEC] | wv[B_EXEC];
    return r;
  endfunction

endpackage

// File: rtl/sfr_cfg_reg.sv
module sfr_cfg_reg
  import sfr_pkg::*;
#(
  parameter logic [31:0] RST     = 32'h0,
  parameter bit          HAS_CMM = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wv,
  output logic [31:0] q
);

  logic [31:0] nxt;

  always_comb nxt = cfg_next(q, wv, HAS_CMM);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RST;
    else if (we) q <= nxt;
  end

endmodule

// File: rtl/sfr_cts.sv
module sfr_cts
  import sfr_pkg::*;
#(
  parameter int NUM_CS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [31:0]       wv,
  input  logic              done,
  output logic [31:0]       q,
  output logic              start,
  output logic [NUM_CS-1:0] cs_n
);

  localparam logic [2:0] NCS = 3'(NUM_CS);

  logic [31:0] base;
  logic [31:0] nxt;
  logic        go;
  logic        cs_take;
  logic        cs_drop;
  logic [2:0]  dev;
  logic        dev_ok;
  logic        sel_vld;
  logic [1:0]  sel_idx;

  always_comb begin
    base    = cts_complete(q, done);
    nxt     = base;
    go      = 1'b0;
    cs_take = 1'b0;
    cs_drop = 1'b0;
    dev     = {1'b0, wv[9:8]};
    dev_ok  = dev < NCS;
    if (we) begin
      nxt = cts_merge(base, wv);
      go  = wv[B_EXEC] & ~base[B_EXEC];
      if (base[B_SWCS] != wv[B_SWCS]) begin
        if (!wv[B_SWCS])                          cs_take = 1'b1;
        else if (!(base[B_EXEC] | wv[B_EXEC]))    cs_drop = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q       <= CTS_RST;
      start   <= 1'b0;
      sel_vld <= 1'b0;
      sel_idx <= 2'd0;
    end else begin
      q     <= nxt;
      start <= go;
      if (cs_take) begin
        sel_vld <= dev_ok;
        sel_idx <= wv[9:8];
      end else if (cs_drop) begin
        sel_vld <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = ~(sel_vld && (sel_idx == 2'(g)));
  end

endmodule

// File: rtl/sfr_rdmux.sv
module sfr_rdmux
  import sfr_pkg::*;
(
  input  widx_t             widx,
  input  logic              valid,
  input  logic [2:0][31:0]  cfg,
  input  logic [31:0]       cts,
  input  logic [31:0]       cmd,
  input  logic [31:0]       adr,
  input  logic [3:0][31:0]  dw,
  input  logic [3:0][31:0]  dr,
  input  logic [31:0]       gcfg,
  output logic [31:0]       val
);

  always_comb begin
    val = 32'h0;
    if (valid) begin
      if (widx == W_DRD || widx == W_DWR || widx == W_UCFG) val = cfg[widx[1:0]];
      else if (widx == W_CTS)                   val = cts;
      else if (widx == W_CMD)                   val = cmd;
      else if (widx == W_ADR)                   val = adr;
      else if (widx == W_PCFG)                  val = PCFG_RST;
      else if (widx[4:2] == W_DW0[4:2])         val = dw[widx[1:0]];
      else if (widx[4:2] == W_DR0[4:2])         val = dr[widx[1:0]];
      else if (widx == W_GCFG)                  val = gcfg;
    end
  end

endmodule

// File: rtl/sflash_regbank.sv
module sflash_regbank
  import sfr_pkg::*;
#(
  parameter int AW     = 12,
  parameter int NUM_CS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              xfer_start,
  input  logic              xfer_done,
  input  logic              rdbuf_we,
  input  logic [1:0]        rdbuf_sel,
  input  logic [31:0]       rdbuf_data,
  output logic [31:0]       rd_cfg_o,
  output logic [31:0]       wr_cfg_o,
  output logic [31:0]       um_cfg_o,
  output logic [31:0]       um_cmd_o,
  output logic [31:0]       um_addr_o,
  output logic [127:0]      um_wdata_o,
  output logic [NUM_CS-1:0] flash_cs_n,
  output logic              irq
);

  localparam int N_CFG = 3;
  localparam int N_BUF = 4;

  widx_t                 widx;
  logic                  acc_ok;
  logic                  wr_ok;
  logic [N_CFG-1:0]      cfg_we;
  logic [N_CFG-1:0][31:0] cfg_q;
  logic [31:0]           cts_q;
  logic [31:0]           cmd_q;
  logic [31:0]           adr_q;
  logic [31:0]           gcfg_q;
  logic [N_BUF-1:0][31:0] dw_q;
  logic [N_BUF-1:0][31:0] dr_q;
  logic [31:0]           rd_val;

  // Named internal events for the checker.
  logic                  cts_exec;
  logic                  cts_rdy;

  assign widx   = bus_addr[6:2];
  assign acc_ok = (bus_addr[1:0] == 2'b00) && (bus_addr[AW-1:7] == '0);
  assign wr_ok  = bus_wr && acc_ok;

  for (genvar g = 0; g < N_CFG; g++) begin : g_cfg
    assign cfg_we[g] = wr_ok && (widx == widx_t'(g));
    sfr_cfg_reg #(
      .RST     (cfg_rst(g)),
      .HAS_CMM (g == int'(W_UCFG))
    ) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we[g]),
      .wv    (bus_wdata),
      .q     (cfg_q[g])
    );
  end

  sfr_cts #(.NUM_CS(NUM_CS)) u_cts (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_ok && widx == W_CTS),
    .wv    (bus_wdata),
    .done  (xfer_done),
    .q     (cts_q),
    .start (xfer_start),
    .cs_n  (flash_cs_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= CMD_RST;
      adr_q  <= '0;
      gcfg_q <= GCFG_RST;
    end else if (wr_ok) begin
      if (widx == W_CMD)  cmd_q  <= bus_wdata;
      if (widx == W_ADR)  adr_q  <= bus_wdata;
      if (widx == W_GCFG) gcfg_q <= bus_wdata;
    end
  end

  for (genvar g = 0; g < N_BUF; g++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rst_n) dw_q[g] <= '0;
      else if (wr_ok && widx == widx_t'(int'(W_DW0) + g)) dw_q[g] <= bus_wdata;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) dr_q[g] <= '0;
      else if (rdbuf_we && rdbuf_sel == 2'(g)) dr_q[g] <= rdbuf_data;
    end
  end

  sfr_rdmux u_rdmux (
    .widx  (widx),
    .valid (acc_ok),
    .cfg   (cfg_q),
    .cts   (cts_q),
    .cmd   (cmd_q),
    .adr   (adr_q),
    .dw    (dw_q),
    .dr    (dr_q),
    .gcfg  (gcfg_q),
    .val   (rd_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  assign cts_exec   = cts_q[B_EXEC];
  assign cts_rdy    = cts_q[B_RDY];
  assign irq        = cts_q[B_RDY] & cts_q[B_IE];
  assign rd_cfg_o   = cfg_q[0];
  assign wr_cfg_o   = cfg_q[1];
  assign um_cfg_o   = cfg_q[2];
  assign um_cmd_o   = cmd_q;
  assign um_addr_o  = adr_q;
  assign um_wdata_o = dw_q;

endmodule

// File: rtl/sflash_regbank_chk.sv
module sflash_regbank_chk #(
  parameter int AW     = 12,
  parameter int NUM_CS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [AW-1:0]     bus_addr,
  input logic              xfer_done,
  input logic              xfer_start,
  input logic [NUM_CS-1:0] flash_cs_n,
  input logic [31:0]       rd_cfg_o,
  input logic [31:0]       um_cfg_o,
  input logic              cts_exec,
  input logic              cts_rdy
);

  AST_DRD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(0) && rd_cfg_o[31]) |=> (rd_cfg_o == $past(rd_cfg_o))); // R2

  AST_CMM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(8) && um_cfg_o[30])
      |=> ((um_cfg_o & 32'h403) == ($past(um_cfg_o) & 32'h403))); // R3

  AST_RDY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !(bus_wr && bus_addr == AW'(12))) |=> cts_rdy); // R4

  AST_EXEC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_exec && !xfer_done) |=> cts_exec); // R5

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> cts_exec); // R5

  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~flash_cs_n)); // R6

endmodule

bind sflash_regbank sflash_regbank_chk #(.AW(AW), .NUM_CS(NUM_CS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .xfer_done  (xfer_done),
  .xfer_start (xfer_start),
  .flash_cs_n (flash_cs_n),
  .rd_cfg_o   (rd_cfg_o),
  .um_cfg_o   (um_cfg_o),
  .cts_exec   (cts_exec),
  .cts_rdy    (cts_rdy)
);

// File: tb/sflash_regbank_tb.sv
module sflash_regbank_tb;

  localparam int AW  = 12;
  localparam int NCS = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_wr = 1'b0;
  logic           bus_rd = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic           xfer_start;
  logic           xfer_done = 1'b0;
  logic           rdbuf_we = 1'b0;
  logic [1:0]     rdbuf_sel = '0;
  logic [31:0]    rdbuf_data = '0;
  logic [31:0]    rd_cfg_o, wr_cfg_o, um_cfg_o, um_cmd_o, um_addr_o;
  logic [127:0]   um_wdata_o;
  logic [NCS-1:0] flash_cs_n;
  logic           irq;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  sflash_regbank #(.AW(AW), .NUM_CS(NCS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .xfer_start(xfer_start), .xfer_done(xfer_done), .rdbuf_we(rdbuf_we),
    .rdbuf_sel(rdbuf_sel), .rdbuf_data(rdbuf_data), .rd_cfg_o(rd_cfg_o),
    .wr_cfg_o(wr_cfg_o), .um_cfg_o(um_cfg_o), .um_cmd_o(um_cmd_o),
    .um_addr_o(um_addr_o), .um_wdata_o(um_wdata_o), .flash_cs_n(flash_cs_n),
    .irq(irq)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] mr [0:31];
  int          msel;
  bit          mstart;
  logic [31:0] mrd;

  function automatic logic [31:0] mread(input logic [AW-1:0] a);
    int w;
    if (a[1:0] != 2'b00 || a >= 128) return 32'h0;
    w = int'(a) / 4;
    if (w <= 5 || (w >= 8 && w <= 15) || w == 30) return mr[w];
    if (w == 6) return 32'h400;
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    logic [31:0] c, v;
    int w;
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) mr[i] = 32'h0;
      mr[0] = 32'h0300100B; mr[1] = 32'h03000002; mr[2] = 32'h00000400;
      mr[3] = 32'h00010000; mr[4] = 32'h0000000B; mr[30] = 32'h0000000B;
      msel = -1; mstart = 0; mrd = 0;
    end else begin
      mstart = 0;
      if (bus_rd) mrd = mread(bus_addr);
      if (xfer_done) begin mr[3][0] = 1'b0; mr[3][24] = 1'b1; end
      if (rdbuf_we) mr[12 + int'(rdbuf_sel)] = rdbuf_data;
      if (bus_wr && bus_addr[1:0] == 2'b00 && bus_addr < 128) begin
        w = int'(bus_addr) / 4;
        v = bus_wdata;
        if (w <= 2) begin
          if (!mr[w][31]) begin
            if (w == 2 && mr[2][30]) v = (v & ~32'h403) | (mr[2] & 32'h403);
            mr[w] = v;
          end
        end else if (w == 3) begin
          c = mr[3];
          if (v[16] != c[16]) begin
            if (!v[16]) msel = (int'(v[9:8]) < NCS) ? int'(v[9:8]) : -1;
            else if (!c[0] && !v[0]) msel = -1;
          end
          if (!c[0] && v[0]) mstart = 1;
          v[24] = v[24] ? 1'b0 : c[24];
          if (c[0]) v[0] = 1'b1;
          mr[3] = v;
        end else if (w == 4 || w == 5 || (w >= 8 && w <= 11) || w == 30) begin
          mr[w] = v;
        end
      end
    end
  end

  // Compare every cycle, away from the rising edge.
  always @(negedge clk) begin
    logic [NCS-1:0] ecs;
    if (rst_n) begin
      for (int i = 0; i < NCS; i++) ecs[i] = !(msel == i);
      chk(flash_cs_n === ecs, "R6 chip select", 128'(flash_cs_n), 128'(ecs));
      chk(irq === (mr[3][24] & mr[3][25]), "R9 irq", 128'(irq), 128'(mr[3][24] & mr[3][25]));
      chk(xfer_start === mstart, "R5 start pulse", 128'(xfer_start), 128'(mstart));
      chk(bus_rdata === mrd, "R10 read data", 128'(bus_rdata), 128'(mrd));
      chk(rd_cfg_o === mr[0], "R2 direct-read cfg", 128'(rd_cfg_o), 128'(mr[0]));
      chk(wr_cfg_o === mr[1], "R2 direct-write cfg", 128'(wr_cfg_o), 128'(mr[1]));
      chk(um_cfg_o === mr[2], "R3 user cfg", 128'(um_cfg_o), 128'(mr[2]));
      chk(um_cmd_o === mr[4] && um_addr_o === mr[5], "R10 cmd/addr",
          {um_cmd_o, um_addr_o}, {mr[4], mr[5]});
      chk(um_wdata_o === {mr[11], mr[10], mr[9], mr[8]}, "R10 wdata",
          um_wdata_o, {mr[11], mr[10], mr[9], mr[8]});
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
    chk(bus_rdata === e, tag, 128'(bus_rdata), 128'(e));
  endtask

  task automatic done_pulse();
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
  endtask

  task automatic eng_wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); rdbuf_we = 1'b1; rdbuf_sel = s; rdbuf_data = d;
    @(negedge clk); rdbuf_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R1 act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    chk(flash_cs_n === 3'b111 && irq === 1'b0, "R1 cs/irq at reset",
        {flash_cs_n, irq}, {3'b111, 1'b0});
    rd_exp(12'h000, 32'h0300100B, "R1 direct-read");
    rd_exp(12'h004, 32'h03000002, "R1 direct-write");
    rd_exp(12'h008, 32'h00000400, "R1 user cfg");
    rd_exp(12'h00C, 32'h00010000, "R1 ctrl/status");
    rd_exp(12'h010, 32'h0000000B, "R1 command");
    rd_exp(12'h018, 32'h00000400, "R1 protection cfg");
    rd_exp(12'h078, 32'h0000000B, "R1 global");
    rd_exp(12'h030, 32'h0, "R1 read-data word");

    // R10 plain words
    wr(12'h010, 32'h0000009F); rd_exp(12'h010, 32'h0000009F, "R10 command");
    wr(12'h014, 32'h00ABCDEF); rd_exp(12'h014, 32'h00ABCDEF, "R10 address");
    for (int i = 0; i < 4; i++) wr(AW'(32 + 4 * i), 32'h11110000 + 32'(i));
    rd_exp(12'h02C, 32'h11110003, "R10 write-data word 3");
    chk(um_wdata_o[31:0] === 32'h11110000, "R10 wdata word 0", 128'(um_wdata_o[31:0]), 128'h11110000);
    wr(12'h078, 32'h5A5A0001); rd_exp(12'h078, 32'h5A5A0001, "R10 global");

    // R2 self-locking
    wr(12'h000, 32'h00021234); rd_exp(12'h000, 32'h00021234, "R2 unlocked write");
    wr(12'h000, 32'h80000055); wr(12'h000, 32'h0);
    rd_exp(12'h000, 32'h80000055, "R2 direct-read locked");
    wr(12'h004, 32'h80000077); wr(12'h004, 32'h12345678);
    rd_exp(12'h004, 32'h80000077, "R2 direct-write locked");

    // R3 command-mode lock
    wr(12'h008, 32'h40000401);
    wr(12'h008, 32'h00000002);
    rd_exp(12'h008, 32'h00000401, "R3 frozen bits kept");
    wr(12'h008, 32'h00000002);
    rd_exp(12'h008, 32'h00000002, "R3 lock released");

    // R6 software chip select
    wr(12'h00C, 32'h00000100);
    chk(flash_cs_n === 3'b101, "R6 select cs1", 128'(flash_cs_n), 128'(3'b101));
    wr(12'h00C, 32'h00010100);
    chk(flash_cs_n === 3'b111, "R6 release", 128'(flash_cs_n), 128'(3'b111));
    wr(12'h00C, 32'h00000300);
    chk(flash_cs_n === 3'b111, "R6 number beyond count", 128'(flash_cs_n), 128'(3'b111));
    wr(12'h00C, 32'h00010000);

    // R5 execute, R4 ready, R7 read buffer, R9 irq
    wr(12'h00C, 32'h00010001);
    chk(xfer_start === 1'b1, "R5 start after write", 128'(xfer_start), 128'(1'b1));
    wr(12'h00C, 32'h00010000);
    rd_exp(12'h00C, 32'h00010001, "R5 exec sticky");
    eng_wr(2'd0, 32'hAABBCCDD);
    eng_wr(2'd3, 32'h11223344);
    done_pulse();
    rd_exp(12'h00C, 32'h01010000, "R4 ready set, exec cleared");
    chk(irq === 1'b0, "R9 irq masked", 128'(irq), 128'(1'b0));
    wr(12'h00C, 32'h02010000);
    chk(irq === 1'b1, "R9 irq enabled", 128'(irq), 128'(1'b1));
    rd_exp(12'h00C, 32'h03010000, "R4 write 0 keeps ready");
    wr(12'h00C, 32'h03010000);
    rd_exp(12'h00C, 32'h02010000, "R4 write 1 clears ready");
    rd_exp(12'h030, 32'hAABBCCDD, "R7 read-data 0");
    rd_exp(12'h03C, 32'h11223344, "R7 read-data 3");
    wr(12'h030, 32'h0);
    rd_exp(12'h030, 32'hAABBCCDD, "R7 bus write ignored");

    // R6 release blocked by execute in same write
    wr(12'h00C, 32'h02000000);
    chk(flash_cs_n === 3'b110, "R6 select cs0", 128'(flash_cs_n), 128'(3'b110));
    wr(12'h00C, 32'h02010001);
    chk(flash_cs_n === 3'b110, "R6 release held by exec", 128'(flash_cs_n), 128'(3'b110));
    done_pulse();
    wr(12'h00C, 32'h03000000);
    wr(12'h00C, 32'h02010000);
    chk(flash_cs_n === 3'b111, "R6 release after idle", 128'(flash_cs_n), 128'(3'b111));

    // R8 protection, misaligned and unused offsets
    wr(12'h018, 32'hFFFFFFFF); rd_exp(12'h018, 32'h00000400, "R8 protection cfg");
    wr(12'h040, 32'hFFFFFFFF); rd_exp(12'h040, 32'h0, "R8 protection cmd");
    rd_exp(12'h01C, 32'h0, "R8 unused offset");
    wr(12'h011, 32'hFFFFFFFF); rd_exp(12'h010, 32'h0000009F, "R8 misaligned write");
    rd_exp(12'h012, 32'h0, "R8 misaligned read");
    rd_exp(12'h100, 32'h0, "R8 outside map");

    // R2 user cfg lock
    wr(12'h008, 32'h80000000); wr(12'h008, 32'h00000001);
    rd_exp(12'h008, 32'h80000000, "R2 user cfg locked");

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule